// File: doc/BRIEF.md
# Coalesced Response Splitter Table

This block sits beside a memory request coalescer. Whenever the coalescer issues one wide request on behalf of several lanes, it hands this block a description of what it merged. That description goes into a small table, indexed by the new (coalesced) source ID. For every lane and request slot it holds a valid flag, the original source ID, the word offset inside the wide data and an access size code.

When the wide response comes back, the block uses the response's source ID to read the matching entry combinationally. In the same cycle it drives one output per lane and slot. Each output carries the 32-bit word cut from the response at the stored offset, tagged with the original source ID. Consuming the response frees the entry, so the ID can be reused.

A response whose ID has no live entry produces nothing. Slots that were never filled stay silent.

Top module: `splt_resp_table`

## Requirements
- R1: After reset no table entry is live, so a response on any ID drives every output valid low.
- R2: An allocation (`alloc_valid`) stores the entry under `alloc_id`. A response presented on that ID in any later cycle drives its outputs in the same cycle, with no register between the response inputs and the outputs.
- R3: Each valid output word is taken from `rsp_data` at the stored offset, counted from the least significant end: offset o selects bits o*32+31 down to o*32.
- R4: Slots in different lanes, or different slots of one lane, that store the same offset each receive the identical word.
- R5: Each valid output carries, on `out_src`, the original source ID stored for that lane and slot.
- R6: A slot whose stored valid flag is clear drives its valid output low and its source and data fields as zero.
- R7: Only the 4-byte size code 2 (2'b10) is served. A slot stored with any other size code drives its valid output low and its fields as zero.
- R8: A response on a live ID frees that entry, so a second response on the same ID with no new allocation drives no valid outputs.
- R9: A response on an ID with no live entry drives no valid outputs and leaves all other entries unchanged.
- R10: When an allocation and a response name the same ID in one cycle, the outputs show the old entry. The new entry is stored and stays live for the next response.
- R11: While `rsp_valid` is low, every output valid is low, whatever the table holds.

Output and input slot index k = lane*2 + slot. The field for slot k sits at bits k*W+W-1 down to k*W of each flat vector, where W is that field's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Store a new entry this cycle |
| alloc_id | input | 2 | Coalesced source ID of the new entry |
| alloc_vld | input | 8 | Per-slot valid flags |
| alloc_src | input | 32 | Per-slot original source IDs, 4 bits each |
| alloc_off | input | 16 | Per-slot word offsets, 2 bits each |
| alloc_size | input | 16 | Per-slot size codes, 2 bits each |
| rsp_valid | input | 1 | Coalesced response present |
| rsp_id | input | 2 | Coalesced response source ID |
| rsp_data | input | 128 | Coalesced response data |
| out_valid | output | 8 | Per-slot response valid |
| out_src | output | 32 | Per-slot restored original source IDs |
| out_data | output | 256 | Per-slot extracted words, 32 bits each |

## Verification
The assertions check on every cycle that:
- an allocation leaves its entry live;
- a response on a live ID frees the entry unless it is overwritten in the same cycle;
- a miss leaves the table untouched;
- an idle or missing response keeps all outputs silent;
- slots sharing an offset see equal words.

Only the bench's scenarios can show whether the right bits are sliced out, the right original IDs are restored and the old contents are served when allocation and response collide on one ID. These are compared against a table model held in the bench.

// File: rtl/splt_pkg.sv
package splt_pkg;
    localparam int NUM_LANES     = 4;
    localparam int SLOTS_PER     = 2;
    localparam int NUM_IDS       = 4;
    localparam int NUM_OLD_IDS   = 16;
    localparam int WORD_W        = 32;
    localparam int RSP_W         = 128;

    localparam int NS            = NUM_LANES * SLOTS_PER;
    localparam int ID_W          = $clog2(NUM_IDS);
    localparam int SRC_W         = $clog2(NUM_OLD_IDS);
    localparam int WORDS_PER_RSP = RSP_W / WORD_W;
    localparam int OFF_W         = $clog2(WORDS_PER_RSP);
    localparam int SIZE_W        = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef struct packed {
        logic             vld;
        logic [SRC_W-1:0] src;
        logic [OFF_W-1:0] off;
        size_e            size;
    } slot_t;

    function automatic logic slot_served(slot_t s);
        return s.vld && (s.size == SZ_WORD);
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(logic [RSP_W-1:0] data,
                                                    logic [OFF_W-1:0] off);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < WORDS_PER_RSP; i++) begin
            if (off == OFF_W'(i)) w = data[i*WORD_W +: WORD_W];
        end
        return w;
    endfunction
endpackage

// File: rtl/splt_entry_store.sv
module splt_entry_store
    import splt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ID_W-1:0]     wr_id,
    input  slot_t [NS-1:0]      wr_slots,
    input  logic                rd_en,
    input  logic [ID_W-1:0]     rd_id,
    output logic                rd_hit,
    output slot_t [NS-1:0]      rd_slots
);
    logic [NUM_IDS-1:0] live_q;
    slot_t [NS-1:0]     mem_q [NUM_IDS];

    assign rd_hit   = live_q[rd_id];
    assign rd_slots = mem_q[rd_id];

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else begin
            if (rd_en && live_q[rd_id]) live_q[rd_id] <= 1'b0;
            if (wr_en)                  live_q[wr_id] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_IDS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_id] <= wr_slots;
        end
    end

    AST_ALLOC_LIVE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> live_q[$past(wr_id)]); // R2

    AST_FREE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        (rd_en && live_q[rd_id] && !(wr_en && wr_id == rd_id))
        |=> !live_q[$past(rd_id)]); // R8

    AST_MISS_KEEPS_TABLE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !live_q[rd_id] && !wr_en) |=> (live_q == $past(live_q))); // R9
endmodule

// File: rtl/splt_slot_extract.sv
module splt_slot_extract
    import splt_pkg::*;
(
    input  logic               en,
    input  slot_t              slot,
    input  logic [RSP_W-1:0]   rsp_data,
    output logic               o_valid,
    output logic [SRC_W-1:0]   o_src,
    output logic [WORD_W-1:0]  o_data
);
    always_comb begin
        o_valid = en && slot_served(slot);
        o_src   = o_valid ? slot.src : '0;
        o_data  = o_valid ? pick_word(rsp_data, slot.off) : '0;
    end
endmodule

// File: rtl/splt_resp_table.sv
module splt_resp_table
    import splt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_valid,
    input  logic [ID_W-1:0]          alloc_id,
    input  logic [NS-1:0]            alloc_vld,
    input  logic [NS*SRC_W-1:0]      alloc_src,
    input  logic [NS*OFF_W-1:0]      alloc_off,
    input  logic [NS*SIZE_W-1:0]     alloc_size,
    input  logic                     rsp_valid,
    input  logic [ID_W-1:0]          rsp_id,
    input  logic [RSP_W-1:0]         rsp_data,
    output logic [NS-1:0]            out_valid,
    output logic [NS*SRC_W-1:0]      out_src,
    output logic [NS*WORD_W-1:0]     out_data
);
    slot_t [NS-1:0] wr_slots;
    slot_t [NS-1:0] rd_slots;
    logic           rd_hit;
    logic           lookup_en;

    for (genvar k = 0; k < NS; k++) begin : g_pack
        assign wr_slots[k].vld  = alloc_vld[k];
        assign wr_slots[k].src  = alloc_src[k*SRC_W +: SRC_W];
        assign wr_slots[k].off  = alloc_off[k*OFF_W +: OFF_W];
        assign wr_slots[k].size = size_e'(alloc_size[k*SIZE_W +: SIZE_W]);
    end

    splt_entry_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (alloc_valid),
        .wr_id    (alloc_id),
        .wr_slots (wr_slots),
        .rd_en    (rsp_valid),
        .rd_id    (rsp_id),
        .rd_hit   (rd_hit),
        .rd_slots (rd_slots)
    );

    assign lookup_en = rsp_valid && rd_hit;

    for (genvar k = 0; k < NS; k++) begin : g_slot
        splt_slot_extract u_ext (
            .en       (lookup_en),
            .slot     (rd_slots[k]),
            .rsp_data (rsp_data),
            .o_valid  (out_valid[k]),
            .o_src    (out_src[k*SRC_W +: SRC_W]),
            .o_data   (out_data[k*WORD_W +: WORD_W])
        );
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (out_valid == '0)); // R11

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rd_hit) |-> (out_valid == '0)); // R9

    for (genvar k = 1; k < NS; k++) begin : g_chk
        AST_SAME_OFF_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
            (out_valid[0] && out_valid[k] && rd_slots[0].off == rd_slots[k].off)
            |-> (out_data[0 +: WORD_W] == out_data[k*WORD_W +: WORD_W])); // R4
    end
endmodule

// File: tb/sim_splt_resp_table.sv
module sim_splt_resp_table;
    import splt_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int RND_CYCLES = 3000;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   alloc_valid;
    logic [ID_W-1:0]        alloc_id;
    logic [NS-1:0]          alloc_vld;
    logic [NS*SRC_W-1:0]    alloc_src;
    logic [NS*OFF_W-1:0]    alloc_off;
    logic [NS*SIZE_W-1:0]   alloc_size;
    logic                   rsp_valid;
    logic [ID_W-1:0]        rsp_id;
    logic [RSP_W-1:0]       rsp_data;
    logic [NS-1:0]          out_valid;
    logic [NS*SRC_W-1:0]    out_src;
    logic [NS*WORD_W-1:0]   out_data;

    int checks = 0;
    int failures = 0;

    logic                  m_live [NUM_IDS];
    logic [NS-1:0]         m_vld  [NUM_IDS];
    logic [NS*SRC_W-1:0]   m_src  [NUM_IDS];
    logic [NS*OFF_W-1:0]   m_off  [NUM_IDS];
    logic [NS*SIZE_W-1:0]  m_size [NUM_IDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    splt_resp_table u0 (.*);

    task automatic check(input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        alloc_valid = 0; alloc_id = '0; alloc_vld = '0; alloc_src = '0;
        alloc_off = '0; alloc_size = '0;
        rsp_valid = 0; rsp_id = '0; rsp_data = '0;
    endtask

    // Inputs already set at a falling edge; check, update model, move to next falling edge.
    task automatic step(input string tag);
        logic [NS-1:0]        ev;
        logic [NS*SRC_W-1:0]  es;
        logic [NS*WORD_W-1:0] ed;
        #1;
        ev = '0; es = '0; ed = '0;
        if (rsp_valid && m_live[rsp_id]) begin
            for (int k = 0; k < NS; k++) begin
                if (m_vld[rsp_id][k] && m_size[rsp_id][k*SIZE_W +: SIZE_W] == 2'd2) begin
                    ev[k] = 1'b1;
                    es[k*SRC_W +: SRC_W] = m_src[rsp_id][k*SRC_W +: SRC_W];
                    ed[k*WORD_W +: WORD_W] =
                        rsp_data[32*int'(m_off[rsp_id][k*OFF_W +: OFF_W]) +: 32];
                end
            end
        end
        check(tag, "valid", 256'(out_valid), 256'(ev));
        check(tag, "src",   256'(out_src),   256'(es));
        check(tag, "data",  256'(out_data),  256'(ed));
        if (rsp_valid && m_live[rsp_id]) m_live[rsp_id] = 1'b0;
        if (alloc_valid) begin
            m_live[alloc_id] = 1'b1;
            m_vld[alloc_id]  = alloc_vld;
            m_src[alloc_id]  = alloc_src;
            m_off[alloc_id]  = alloc_off;
            m_size[alloc_id] = alloc_size;
        end
        @(negedge clk);
    endtask

    task automatic set_alloc(input logic [ID_W-1:0] id, input logic [NS-1:0] v,
                             input int src_base, input int off_mode, input int size_mode);
        alloc_valid = 1; alloc_id = id; alloc_vld = v;
        for (int k = 0; k < NS; k++) begin
            alloc_src[k*SRC_W +: SRC_W]   = SRC_W'(src_base + k);
            alloc_off[k*OFF_W +: OFF_W]   = (off_mode < 0) ? OFF_W'(k) : OFF_W'(off_mode);
            alloc_size[k*SIZE_W +: SIZE_W] = (size_mode < 0) ? SIZE_W'(k) : SIZE_W'(size_mode);
        end
    endtask

    task automatic set_rsp(input logic [ID_W-1:0] id);
        rsp_valid = 1; rsp_id = id;
        rsp_data = {32'h0123_4567, 32'h89AB_CDEF, 32'h5CA1_AB1E, 32'hDEAD_BEEF}
                   ^ {4{$urandom()}};
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NUM_IDS; i++) begin
            m_live[i] = 0; m_vld[i] = '0; m_src[i] = '0; m_off[i] = '0; m_size[i] = '0;
        end
        clear_in();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: nothing live after reset
        for (int i = 0; i < NUM_IDS; i++) begin
            clear_in(); set_rsp(ID_W'(i)); step("R1");
        end

        // R2 R3 R5: allocate with distinct offsets, respond next cycle
        clear_in(); set_alloc(2'd1, '1, 3, -1, 2); step("R2");
        clear_in(); set_rsp(2'd1); step("R2 R3 R5");
        // R8: second response on freed ID
        clear_in(); set_rsp(2'd1); step("R8");

        // R4: all slots share offset 1
        clear_in(); set_alloc(2'd2, '1, 0, 1, 2); step("R4");
        clear_in(); set_rsp(2'd2); step("R4");

        // R6: sparse valid flags
        clear_in(); set_alloc(2'd3, 8'b1010_0101, 8, -1, 2); step("R6");
        clear_in(); set_rsp(2'd3); step("R6");

        // R7: mixed size codes, only code 2 served
        clear_in(); set_alloc(2'd0, '1, 5, 3, -1); step("R7");
        clear_in(); set_rsp(2'd0); step("R7");

        // R9: miss on empty ID leaves live ID 1 intact
        clear_in(); set_alloc(2'd1, '1, 2, 2, 2); step("R9");
        clear_in(); set_rsp(2'd2); step("R9");
        clear_in(); set_rsp(2'd1); step("R9");

        // R11: live entry but no response
        clear_in(); set_alloc(2'd1, '1, 7, 0, 2); step("R11");
        clear_in(); step("R11");

        // R10: allocate and respond on the same ID in one cycle
        clear_in(); set_alloc(2'd1, 8'b0000_1111, 11, 3, 2); set_rsp(2'd1); step("R10");
        clear_in(); set_rsp(2'd1); step("R10");

        // Random mix
        for (int n = 0; n < RND_CYCLES; n++) begin
            clear_in();
            if ($urandom_range(1, 0) == 1) begin
                alloc_valid = 1;
                alloc_id    = ID_W'($urandom());
                alloc_vld   = NS'($urandom());
                alloc_src   = (NS*SRC_W)'($urandom());
                alloc_off   = (NS*OFF_W)'($urandom());
                for (int k = 0; k < NS; k++)
                    alloc_size[k*SIZE_W +: SIZE_W] =
                        ($urandom_range(3, 0) != 0) ? 2'd2 : SIZE_W'($urandom());
            end
            if ($urandom_range(1, 0) == 1) begin
                rsp_valid = 1;
                rsp_id    = ID_W'($urandom());
                rsp_data  = {$urandom(), $urandom(), $urandom(), $urandom()};
            end
            step("RND R3 R5 R6 R7 R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule